// File: doc/BRIEF.md
# Hart Debug Halt Control

This block is the per-hart controller that decides when a processor hart stops in debug mode and when it runs again. It takes requests to halt, to resume and to halt straight out of reset, plus the hart's own events: a breakpoint instruction, a trigger match and an instruction-retire strobe. From these it drives a debug-mode flag, an issue enable for the pipeline, an interrupt mask, and freeze gates for the cycle/instret counters and the timer.

It also holds a small debug control word. The word carries a single-step bit, a step-interrupt enable, a counter-stop bit and a timer-stop bit, and it reports the cause of the most recent entry into debug mode. A memory-privilege-override enable bit reads as constant 1. The debug module writes the word only while the hart is halted. The hart then resumes, either to run freely or to retire exactly one instruction before stopping again.

The reset input is taken as already released in step with the clock. The halt-on-reset request is expected to be held by the debug module across reset, and it is sampled in the first cycle after reset ends. No instruction may issue during that cycle.

Top module: `hart_dbg_ctl`

## Requirements
- R1: In the first cycle after reset, run_en_o is 0. If rst_halt_req_i is 1 in that cycle, the hart is halted from the next edge with cause 5 and never issues. Otherwise run_en_o rises at that edge.
- R2: While running or stepping, ebreak_i, trigger_i or halt_req_i halts the hart at the next edge. The recorded cause is 1, 2 or 3 respectively, and the lowest number wins when several coincide. These inputs are ignored while halted.
- R3: A resume_req_i while halted with halt_req_i low clears dbg_mode_o at the next edge. A resume while not halted, or while halt_req_i is high, has no effect.
- R4: With the step bit set, a resume enters stepping. The first retire_i halts the hart at the next edge with cause 4, unless a lower cause coincides. With the step bit clear, retirements never halt the hart.
- R5: cnt_stop_o is 1 exactly when the hart is halted and the counter-stop bit (bit 2) is 1.
- R6: tmr_stop_o is 1 exactly when the hart is halted and the timer-stop bit (bit 3) is 1.
- R7: Bit 4 of ctl_rdata_o (memory-privilege-override enable) always reads 1, and writes to it have no effect.
- R8: Bit 1 (step-interrupt enable) reads 0 and ignores writes in the default build. irq_mask_o is 1 whenever the hart is not freely running (halted, booting or stepping). irq_take_o equals irq_pend_i and not irq_mask_o in the same cycle.
- R9: ctl_we_i updates bit 0 (step), bit 2 and bit 3 from ctl_wdata_i only while halted, and the new value is visible at the next edge. Writes at other times and writes to bits 7:5 (the cause field) are ignored.
- R10: During reset: the step bit is 0, both stop bits are 1, the cause is 0, dbg_mode_o is 0 and run_en_o is 0, so ctl_rdata_o reads 8'h1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| halt_req_i | input | 1 | Request to halt the hart |
| resume_req_i | input | 1 | Request to resume a halted hart |
| rst_halt_req_i | input | 1 | Halt-on-reset request, sampled in the first cycle after reset |
| ebreak_i | input | 1 | Breakpoint instruction executed |
| trigger_i | input | 1 | Trigger match requesting debug entry |
| retire_i | input | 1 | One instruction retired this cycle |
| irq_pend_i | input | 1 | Interrupt pending |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word write data |
| dbg_mode_o | output | 1 | Hart is in debug mode |
| run_en_o | output | 1 | Hart may issue instructions |
| irq_mask_o | output | 1 | Interrupts are masked |
| irq_take_o | output | 1 | Pending interrupt may be taken |
| cnt_stop_o | output | 1 | Freeze cycle and instret counters |
| tmr_stop_o | output | 1 | Freeze timer increment |
| ctl_rdata_o | output | 8 | Control word: step, step-irq enable, counter stop, timer stop, override enable, cause[7:5] |

## Verification
The mode flag, issue enable, mask and stop gates are registered outputs. They change at the first clock edge after the input that caused the change, and the cause field and written control bits appear on ctl_rdata_o at that same edge. irq_take_o is the one output that also follows irq_pend_i within the same cycle. The behavioural reference in the bench advances at each rising edge from the inputs held since the previous falling edge, and every output is compared to it five time units after the edge. Directed checks sample one falling edge after each stimulus, which is exactly one register stage later.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

  // Control word layout
  localparam int BIT_STEP    = 0;
  localparam int BIT_STEPIE  = 1;
  localparam int BIT_STOPCNT = 2;
  localparam int BIT_STOPTMR = 3;
  localparam int BIT_MPRV    = 4;
  localparam int CAUSE_LSB   = 5;
  localparam int CAUSE_W     = 3;
  localparam int CTL_W       = CAUSE_LSB + CAUSE_W;

  // Entry cause codes; a lower code has priority
  localparam logic [CAUSE_W-1:0] CS_NONE    = 3'd0;
  localparam logic [CAUSE_W-1:0] CS_EBREAK  = 3'd1;
  localparam logic [CAUSE_W-1:0] CS_TRIG    = 3'd2;
  localparam logic [CAUSE_W-1:0] CS_HALTREQ = 3'd3;
  localparam logic [CAUSE_W-1:0] CS_STEP    = 3'd4;
  localparam logic [CAUSE_W-1:0] CS_RSTHALT = 3'd5;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2,
    ST_STEP = 2'd3
  } hdc_state_e;

endpackage

// File: rtl/hdc_cause_pick.sv
module hdc_cause_pick
  import hdc_pkg::*;
(
  input  logic               ebreak_i,
  input  logic               trig_i,
  input  logic               halt_i,
  input  logic               step_done_i,
  output logic               hit_o,
  output logic [CAUSE_W-1:0] cause_o
);

  always_comb begin
    hit_o   = 1'b1;
    cause_o = CS_NONE;
    if (ebreak_i) begin
      cause_o = CS_EBREAK;
    end else if (trig_i) begin
      cause_o = CS_TRIG;
    end else if (halt_i) begin
      cause_o = CS_HALTREQ;
    end else if (step_done_i) begin
      cause_o = CS_STEP;
    end else begin
      hit_o = 1'b0;
    end
  end

endmodule

// File: rtl/hdc_fsm.sv
module hdc_fsm
  import hdc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rst_halt_i,
  input  logic               ebreak_i,
  input  logic               trig_i,
  input  logic               halt_i,
  input  logic               resume_i,
  input  logic               retire_i,
  input  logic               step_i,
  output hdc_state_e         state_o,
  output logic [CAUSE_W-1:0] cause_o
);

  hdc_state_e         state_q, state_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               cause_en;
  logic               pick_hit;
  logic [CAUSE_W-1:0] pick_cause;
  logic               step_done;

  assign step_done = (state_q == ST_STEP) && retire_i;

  hdc_cause_pick u_pick (
    .ebreak_i    (ebreak_i),
    .trig_i      (trig_i),
    .halt_i      (halt_i),
    .step_done_i (step_done),
    .hit_o       (pick_hit),
    .cause_o     (pick_cause)
  );

  always_comb begin
    state_d  = state_q;
    cause_d  = cause_q;
    cause_en = 1'b0;
    unique case (state_q)
      ST_BOOT: begin
        if (rst_halt_i) begin
          state_d  = ST_HALT;
          cause_d  = CS_RSTHALT;
          cause_en = 1'b1;
        end else begin
          state_d = ST_RUN;
        end
      end
      ST_RUN, ST_STEP: begin
        if (pick_hit) begin
          state_d  = ST_HALT;
          cause_d  = pick_cause;
          cause_en = 1'b1;
        end
      end
      ST_HALT: begin
        if (resume_i && !halt_i) begin
          state_d = step_i ? ST_STEP : ST_RUN;
        end
      end
      default: state_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CS_NONE;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign state_o = state_q;
  assign cause_o = cause_q;

endmodule

// File: rtl/hdc_ctl_reg.sv
module hdc_ctl_reg
  import hdc_pkg::*;
#(
  parameter bit STEPIE_SUPPORTED = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               wr_ok_i,
  input  logic [CTL_W-1:0]   wdata_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic               step_o,
  output logic               stepie_o,
  output logic               stopcnt_o,
  output logic               stoptmr_o,
  output logic [CTL_W-1:0]   rdata_o
);

  logic wr_en;
  logic step_q, step_d;
  logic stopc_q, stopc_d;
  logic stopt_q, stopt_d;
  logic unused_wd;

  assign wr_en     = we_i && wr_ok_i;
  assign unused_wd = ^{wdata_i[CTL_W-1:CAUSE_LSB], wdata_i[BIT_MPRV]};

  always_comb begin
    step_d  = step_q;
    stopc_d = stopc_q;
    stopt_d = stopt_q;
    if (wr_en) begin
      step_d  = wdata_i[BIT_STEP];
      stopc_d = wdata_i[BIT_STOPCNT];
      stopt_d = wdata_i[BIT_STOPTMR];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= 1'b0;
      stopc_q <= 1'b1;
      stopt_q <= 1'b1;
    end else begin
      step_q  <= step_d;
      stopc_q <= stopc_d;
      stopt_q <= stopt_d;
    end
  end

  generate
    if (STEPIE_SUPPORTED) begin : g_stepie
      logic stepie_q, stepie_d;
      always_comb begin
        stepie_d = stepie_q;
        if (wr_en) begin
          stepie_d = wdata_i[BIT_STEPIE];
        end
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stepie_q <= 1'b0;
        end else begin
          stepie_q <= stepie_d;
        end
      end
      assign stepie_o = stepie_q;
    end else begin : g_no_stepie
      logic unused_stepie_wd;
      assign unused_stepie_wd = wdata_i[BIT_STEPIE];
      assign stepie_o         = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata_o                          = '0;
    rdata_o[BIT_STEP]                = step_q;
    rdata_o[BIT_STEPIE]              = stepie_o;
    rdata_o[BIT_STOPCNT]             = stopc_q;
    rdata_o[BIT_STOPTMR]             = stopt_q;
    rdata_o[BIT_MPRV]                = 1'b1;
    rdata_o[CAUSE_LSB +: CAUSE_W]    = cause_i;
  end

  assign step_o    = step_q;
  assign stopcnt_o = stopc_q;
  assign stoptmr_o = stopt_q;

endmodule

// File: rtl/hdc_gate.sv
module hdc_gate
  import hdc_pkg::*;
(
  input  hdc_state_e state_i,
  input  logic       stepie_i,
  input  logic       stopcnt_i,
  input  logic       stoptmr_i,
  input  logic       irq_pend_i,
  output logic       dbg_mode_o,
  output logic       run_en_o,
  output logic       irq_mask_o,
  output logic       irq_take_o,
  output logic       cnt_stop_o,
  output logic       tmr_stop_o
);

  logic halted;
  logic stepping;

  assign halted     = (state_i == ST_HALT);
  assign stepping   = (state_i == ST_STEP);
  assign dbg_mode_o = halted;
  assign run_en_o   = (state_i == ST_RUN) || stepping;
  assign irq_mask_o = halted || (state_i == ST_BOOT) || (stepping && !stepie_i);
  assign irq_take_o = irq_pend_i && !irq_mask_o;
  assign cnt_stop_o = halted && stopcnt_i;
  assign tmr_stop_o = halted && stoptmr_i;

endmodule

// File: rtl/hart_dbg_ctl.sv
module hart_dbg_ctl
  import hdc_pkg::*;
#(
  parameter bit STEPIE_SUPPORTED = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             halt_req_i,
  input  logic             resume_req_i,
  input  logic             rst_halt_req_i,
  input  logic             ebreak_i,
  input  logic             trigger_i,
  input  logic             retire_i,
  input  logic             irq_pend_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic             dbg_mode_o,
  output logic             run_en_o,
  output logic             irq_mask_o,
  output logic             irq_take_o,
  output logic             cnt_stop_o,
  output logic             tmr_stop_o,
  output logic [CTL_W-1:0] ctl_rdata_o
);

  hdc_state_e         state;
  logic [CAUSE_W-1:0] cause;
  logic               step_bit;
  logic               stepie_bit;
  logic               stopcnt_bit;
  logic               stoptmr_bit;

  hdc_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_halt_i (rst_halt_req_i),
    .ebreak_i   (ebreak_i),
    .trig_i     (trigger_i),
    .halt_i     (halt_req_i),
    .resume_i   (resume_req_i),
    .retire_i   (retire_i),
    .step_i     (step_bit),
    .state_o    (state),
    .cause_o    (cause)
  );

  hdc_ctl_reg #(
    .STEPIE_SUPPORTED (STEPIE_SUPPORTED)
  ) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctl_we_i),
    .wr_ok_i   (state == ST_HALT),
    .wdata_i   (ctl_wdata_i),
    .cause_i   (cause),
    .step_o    (step_bit),
    .stepie_o  (stepie_bit),
    .stopcnt_o (stopcnt_bit),
    .stoptmr_o (stoptmr_bit),
    .rdata_o   (ctl_rdata_o)
  );

  hdc_gate u_gate (
    .state_i    (state),
    .stepie_i   (stepie_bit),
    .stopcnt_i  (stopcnt_bit),
    .stoptmr_i  (stoptmr_bit),
    .irq_pend_i (irq_pend_i),
    .dbg_mode_o (dbg_mode_o),
    .run_en_o   (run_en_o),
    .irq_mask_o (irq_mask_o),
    .irq_take_o (irq_take_o),
    .cnt_stop_o (cnt_stop_o),
    .tmr_stop_o (tmr_stop_o)
  );

endmodule

// File: rtl/hart_dbg_ctl_chk.sv
module hart_dbg_ctl_chk #(
  parameter bit STEPIE_SUPPORTED = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       halt_req_i,
  input logic       resume_req_i,
  input logic       ebreak_i,
  input logic       trigger_i,
  input logic       retire_i,
  input logic       irq_pend_i,
  input logic       dbg_mode_o,
  input logic       run_en_o,
  input logic       irq_mask_o,
  input logic       irq_take_o,
  input logic       cnt_stop_o,
  input logic       tmr_stop_o,
  input logic [7:0] ctl_rdata_o
);

  AST_HALT_NO_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_mode_o |-> (!run_en_o && irq_mask_o)); // R8

  AST_EVENT_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_o && (ebreak_i || trigger_i || halt_req_i)) |=> dbg_mode_o); // R2

  AST_EBREAK_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_o && ebreak_i) |=> (ctl_rdata_o[7:5] == 3'd1)); // R2

  AST_RESUME_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_mode_o && resume_req_i && !halt_req_i) |=> !dbg_mode_o); // R3

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_en_o && ctl_rdata_o[0] && retire_i) |=> dbg_mode_o); // R4

  AST_CTL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_mode_o |=> $stable(ctl_rdata_o[3:0])); // R9

  AST_STOP_ONLY_HALTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_stop_o || tmr_stop_o) |-> dbg_mode_o); // R5

  AST_IRQ_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (irq_pend_i && !irq_mask_o)); // R8

  generate
    if (!STEPIE_SUPPORTED) begin : g_step_mask
      AST_STEP_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en_o && ctl_rdata_o[0]) |-> irq_mask_o); // R8
    end
  endgenerate

endmodule

bind hart_dbg_ctl hart_dbg_ctl_chk #(.STEPIE_SUPPORTED(STEPIE_SUPPORTED)) chk_i (.*);

// File: tb/hart_dbg_ctl_tb_top.sv
module hart_dbg_ctl_tb_top;

  // 20 time units per period: 50 MHz at nanosecond scale
  logic       clk;
  logic       rst_n;
  logic       halt_req, resume_req, rst_halt_req, ebreak, trigger, retire, irq_pend;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic       dbg_mode, run_en, irq_mask, irq_take, cnt_stop, tmr_stop;
  logic [7:0] ctl_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int n_cyc = 0;
  bit done  = 1'b0;

  hart_dbg_ctl dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .halt_req_i     (halt_req),
    .resume_req_i   (resume_req),
    .rst_halt_req_i (rst_halt_req),
    .ebreak_i       (ebreak),
    .trigger_i      (trigger),
    .retire_i       (retire),
    .irq_pend_i     (irq_pend),
    .ctl_we_i       (ctl_we),
    .ctl_wdata_i    (ctl_wdata),
    .dbg_mode_o     (dbg_mode),
    .run_en_o       (run_en),
    .irq_mask_o     (irq_mask),
    .irq_take_o     (irq_take),
    .cnt_stop_o     (cnt_stop),
    .tmr_stop_o     (tmr_stop),
    .ctl_rdata_o    (ctl_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 boot, 1 run, 2 halted, 3 stepping
  int   m_st;
  logic m_step, m_stopc, m_stopt;
  int   m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_step = 0; m_stopc = 1; m_stopt = 1; m_cause = 0;
    end else begin
      int nxt;
      nxt = m_st;
      if (m_st == 0) begin
        if (rst_halt_req) begin nxt = 2; m_cause = 5; end
        else nxt = 1;
      end else if (m_st == 1 || m_st == 3) begin
        if (ebreak) begin nxt = 2; m_cause = 1; end
        else if (trigger) begin nxt = 2; m_cause = 2; end
        else if (halt_req) begin nxt = 2; m_cause = 3; end
        else if (m_st == 3 && retire) begin nxt = 2; m_cause = 4; end
      end else begin
        if (resume_req && !halt_req) nxt = m_step ? 3 : 1;
        if (ctl_we) begin
          m_step = ctl_wdata[0]; m_stopc = ctl_wdata[2]; m_stopt = ctl_wdata[3];
        end
      end
      m_st = nxt;
    end
  end

  // Compare every cycle, mid-way after the edge
  always @(posedge clk) begin
    #5;
    if (!done) begin
      logic e_dbg, e_run, e_mask;
      e_dbg  = (m_st == 2);
      e_run  = (m_st == 1) || (m_st == 3);
      e_mask = (m_st != 1);
      check("R2 dbg_mode", {7'd0, dbg_mode}, {7'd0, e_dbg});
      check("R1 run_en", {7'd0, run_en}, {7'd0, e_run});
      check("R8 irq_mask", {7'd0, irq_mask}, {7'd0, e_mask});
      check("R8 irq_take", {7'd0, irq_take}, {7'd0, irq_pend & ~e_mask});
      check("R5 cnt_stop", {7'd0, cnt_stop}, {7'd0, e_dbg & m_stopc});
      check("R6 tmr_stop", {7'd0, tmr_stop}, {7'd0, e_dbg & m_stopt});
      check("R9 ctl_rdata", ctl_rdata,
            {m_cause[2:0], 1'b1, m_stopt, m_stopc, 1'b0, m_step});
    end
  end

  // Watchdog
  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 200000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=200000 cycles", n_cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic resume_pulse();
    resume_req = 1'b1;
    @(negedge clk);
    resume_req = 1'b0;
  endtask

  initial begin
    rst_n = 0; halt_req = 0; resume_req = 0; rst_halt_req = 1;
    ebreak = 0; trigger = 0; retire = 0; irq_pend = 0; ctl_we = 0; ctl_wdata = 8'h00;
    repeat (3) @(negedge clk);
    check("R10 reset ctl", ctl_rdata, 8'h1C);
    check("R10 reset run_en", {7'd0, run_en}, 8'h00);
    check("R10 reset dbg_mode", {7'd0, dbg_mode}, 8'h00);
    rst_n = 1;
    retire = 1;                         // must not matter during boot
    @(negedge clk);
    retire = 0;
    check("R1 halted after reset", {7'd0, dbg_mode}, 8'h01);
    check("R1 no issue", {7'd0, run_en}, 8'h00);
    check("R1 cause reset-halt", ctl_rdata, 8'hBC);
    rst_halt_req = 0;

    // Write while halted: step-ie, override and cause bits ignored
    ctl_we = 1; ctl_wdata = 8'hE2;
    @(negedge clk);
    ctl_we = 0;
    check("R7 R8 R9 halted write", ctl_rdata, 8'hB0);
    check("R5 counters run", {7'd0, cnt_stop}, 8'h00);
    check("R6 timer runs", {7'd0, tmr_stop}, 8'h00);

    resume_pulse();
    check("R3 resume clears", {7'd0, dbg_mode}, 8'h00);
    irq_pend = 1;
    #1 check("R8 irq taken running", {7'd0, irq_take}, 8'h01);

    ctl_we = 1; ctl_wdata = 8'h0D;
    @(negedge clk);
    ctl_we = 0;
    check("R9 write while running ignored", ctl_rdata, 8'hB0);

    resume_pulse();
    check("R3 resume while running ignored", {7'd0, run_en}, 8'h01);

    ebreak = 1; trigger = 1; halt_req = 1;
    @(negedge clk);
    ebreak = 0; trigger = 0; halt_req = 0;
    check("R2 ebreak wins", ctl_rdata, 8'h30);
    ebreak = 1;
    @(negedge clk);
    ebreak = 0;
    check("R2 ignored while halted", ctl_rdata, 8'h30);

    resume_pulse();
    trigger = 1; halt_req = 1;
    @(negedge clk);
    trigger = 0; halt_req = 0;
    check("R2 trigger cause", ctl_rdata, 8'h50);

    resume_pulse();
    halt_req = 1;
    @(negedge clk);
    halt_req = 0;
    check("R2 halt cause", ctl_rdata, 8'h70);
    check("R8 no irq while halted", {7'd0, irq_take}, 8'h00);

    ctl_we = 1; ctl_wdata = 8'h0D;
    @(negedge clk);
    ctl_we = 0;
    check("R9 step and stops set", ctl_rdata, 8'h7D);
    check("R5 counters frozen", {7'd0, cnt_stop}, 8'h01);
    check("R6 timer frozen", {7'd0, tmr_stop}, 8'h01);

    halt_req = 1; resume_req = 1;
    @(negedge clk);
    halt_req = 0; resume_req = 0;
    check("R3 resume with halt ignored", {7'd0, dbg_mode}, 8'h01);

    resume_pulse();
    check("R4 stepping", {7'd0, run_en}, 8'h01);
    check("R8 step masks irq", {7'd0, irq_take}, 8'h00);
    repeat (2) @(negedge clk);
    check("R4 waits for retire", {7'd0, dbg_mode}, 8'h00);
    retire = 1;
    @(negedge clk);
    retire = 0;
    check("R4 step re-entry", ctl_rdata, 8'h9D);
    check("R4 halted after step", {7'd0, dbg_mode}, 8'h01);

    resume_pulse();
    retire = 1; trigger = 1;
    @(negedge clk);
    retire = 0; trigger = 0;
    check("R4 lower cause wins", ctl_rdata, 8'h5D);

    ctl_we = 1; ctl_wdata = 8'h0C;
    @(negedge clk);
    ctl_we = 0;
    resume_pulse();
    retire = 1;
    repeat (4) @(negedge clk);
    retire = 0;
    check("R4 no step keeps running", {7'd0, run_en}, 8'h01);
    irq_pend = 0;

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 no reset-halt runs", {7'd0, run_en}, 8'h01);
    check("R10 ctl after reset", ctl_rdata, 8'h1C);
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule